// File: doc/BRIEF.md
# Dual-Channel Interrupt Gate

This block merges the interrupt requests from two disk channels onto one shared interrupt line. Each channel has its own mask bit. Software changes a mask bit only through the type of bus access it makes to that channel's control location. A write of any value unmasks the channel. A read masks it. The data on the bus plays no part in either case.

A second location for each channel returns the raw request from that channel's drive, whether the channel is masked or not. This lets software poll for a request while the line is gated off. To route the line to one channel, software writes that channel's control location and reads the other channel's control location. This leaves exactly one channel able to raise the shared output.

The register bus is byte-wide. It has a 12-bit address and separate read and write strobes. Every access completes in one cycle. Read data is combinational from the address. A mask change takes effect at the clock edge that ends the access.

Top module: `irq_gate_top`

## Requirements
- R1: After the active-low reset, both channels are masked, so `irq_o` is 0 even when both drive requests are high.
- R2: A write of any data value to a channel's control location (channel 0 at 0x880, channel 1 at 0xC80) unmasks that channel from the next clock edge.
- R3: A read of a channel's control location masks that channel from the next clock edge. The read returns 0x00.
- R4: A read of a channel's status location (channel 0 at 0x8A4, channel 1 at 0xCA4) returns that channel's drive request in bit 0 and zeros in bits 7:1. The result is the same whether the channel is masked or not.
- R5: `irq_o` is high exactly when at least one channel has both its drive request high and its mask bit cleared.
- R6: An access to one channel's control location leaves the other channel's mask unchanged.
- R7: A write to a status location or to an unmapped address changes no mask bit. A read of an unmapped address changes no mask bit and returns 0x00.
- R8: When the read and write strobes are both high on the same control location, the write takes priority and the channel ends up unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Register address |
| rd_i | input | 1 | Read strobe, one cycle per access |
| wr_i | input | 1 | Write strobe, one cycle per access |
| wdata_i | input | 8 | Write data (ignored) |
| rdata_o | output | 8 | Read data |
| drv_irq_i | input | 2 | Raw drive requests, bit n for channel n |
| irq_o | output | 1 | Combined interrupt output |

## Verification
The checker runs on every cycle and covers the following:
- the mask update that follows each control access, with writes taking priority (R2, R3, R8);
- stability of a mask bit when its own control location is not accessed (R6, R7);
- the status read format (R4);
- the conditions that must hold `irq_o` low (R5).

Other behaviour can only be shown by the bench's scenarios:
- that `irq_o` goes high in each unmasked case;
- that the write data is truly ignored;
- that unmapped reads return zero;
- the reset state.

To cover these, the bench sweeps every combination of mask state and drive-request pattern. It also sweeps several write data values and a set of unmapped addresses.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_SET  = 2'd1,
    ACC_CLR  = 2'd2
  } acc_e;

  // location of a channel's register: base plus channel index times stride
  function automatic logic [11:0] chan_loc(input logic [11:0] base,
                                           input logic [11:0] stride,
                                           input int unsigned idx);
    chan_loc = base + 12'(idx) * stride;
  endfunction

endpackage

// File: rtl/irq_gate_decode.sv
module irq_gate_decode
  import irq_gate_pkg::*;
#(
  parameter int unsigned NUM_CH    = 2,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 8,
  parameter logic [11:0] EN_BASE   = 12'h880,
  parameter logic [11:0] ST_BASE   = 12'h8A4,
  parameter logic [11:0] CH_STRIDE = 12'h400
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output acc_e              acc_o [NUM_CH],
  output logic [NUM_CH-1:0] st_sel_o
);

  // control accesses act on the strobe type alone
  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam logic [11:0] EN_LOC = chan_loc(EN_BASE, CH_STRIDE, c);
    localparam logic [11:0] ST_LOC = chan_loc(ST_BASE, CH_STRIDE, c);
    logic en_hit;
    assign en_hit = (addr_i == EN_LOC[ADDR_W-1:0]);

    always_comb begin
      if (en_hit && wr_i)      acc_o[c] = ACC_SET;  // write wins
      else if (en_hit && rd_i) acc_o[c] = ACC_CLR;
      else                     acc_o[c] = ACC_NONE;
    end

    assign st_sel_o[c] = rd_i && (addr_i == ST_LOC[ADDR_W-1:0]);
  end

endmodule

// File: rtl/irq_gate_chan.sv
module irq_gate_chan
  import irq_gate_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  acc_e acc_i,
  input  logic drv_irq_i,
  output logic en_o,
  output logic req_o
);

  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
    end else begin
      case (acc_i)
        ACC_SET: en_q <= 1'b1;
        ACC_CLR: en_q <= 1'b0;
        default: en_q <= en_q;
      endcase
    end
  end

  assign en_o  = en_q;
  assign req_o = drv_irq_i & en_q;

endmodule

// File: rtl/irq_gate_top.sv
module irq_gate_top
  import irq_gate_pkg::*;
#(
  parameter int unsigned NUM_CH    = 2,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 8,
  parameter logic [11:0] EN_BASE   = 12'h880,
  parameter logic [11:0] ST_BASE   = 12'h8A4,
  parameter logic [11:0] CH_STRIDE = 12'h400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [11:0]       addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [1:0]        drv_irq_i,
  output logic              irq_o
);

  acc_e              acc [NUM_CH];
  logic [NUM_CH-1:0] st_sel;
  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] req;

  irq_gate_decode #(
    .NUM_CH   (NUM_CH),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .EN_BASE  (EN_BASE),
    .ST_BASE  (ST_BASE),
    .CH_STRIDE(CH_STRIDE)
  ) u_decode (
    .addr_i  (addr_i),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .acc_o   (acc),
    .st_sel_o(st_sel)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    irq_gate_chan u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .acc_i    (acc[c]),
      .drv_irq_i(drv_irq_i[c]),
      .en_o     (en_q[c]),
      .req_o    (req[c])
    );
  end

  assign irq_o = |req;

  // status reads show the raw request; everything else reads zero
  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (st_sel[c]) rdata_o[0] = drv_irq_i[c];
    end
  end

endmodule

// File: rtl/irq_gate_chk.sv
module irq_gate_chk #(
  parameter int unsigned NUM_CH    = 2,
  parameter logic [11:0] EN_BASE   = 12'h880,
  parameter logic [11:0] ST_BASE   = 12'h8A4,
  parameter logic [11:0] CH_STRIDE = 12'h400
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [11:0]       addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [7:0]        rdata_o,
  input logic [1:0]        drv_irq_i,
  input logic              irq_o,
  input logic [NUM_CH-1:0] en_q
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    localparam logic [11:0] EN_LOC = EN_BASE + 12'(c) * CH_STRIDE;
    localparam logic [11:0] ST_LOC = ST_BASE + 12'(c) * CH_STRIDE;

    // R2 R8
    en_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && addr_i == EN_LOC) |=> en_q[c]);

    // R3
    en_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && !wr_i && addr_i == EN_LOC) |=> !en_q[c]);

    // R6 R7
    en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !((rd_i || wr_i) && addr_i == EN_LOC) |=> $stable(en_q[c]));

    // R4
    st_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_i && addr_i == ST_LOC) |-> rdata_o == {7'b0, drv_irq_i[c]});
  end

  // R5
  irq_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_irq_i == '0 || en_q == '0) |-> !irq_o);

endmodule

bind irq_gate_top irq_gate_chk #(
  .NUM_CH   (NUM_CH),
  .EN_BASE  (EN_BASE),
  .ST_BASE  (ST_BASE),
  .CH_STRIDE(CH_STRIDE)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .rd_i     (rd_i),
  .wr_i     (wr_i),
  .rdata_o  (rdata_o),
  .drv_irq_i(drv_irq_i),
  .irq_o    (irq_o),
  .en_q     (en_q)
);

// File: tb/irq_gate_top_tb.sv
module irq_gate_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] EN0 = 12'h880, EN1 = 12'hC80;
  localparam logic [11:0] ST0 = 12'h8A4, ST1 = 12'hCA4;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic       rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [1:0] drv_irq_i = '0;
  logic       irq_o;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  irq_gate_top u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .rd_i(rd_i),
    .wr_i(wr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .drv_irq_i(drv_irq_i), .irq_o(irq_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // all bus tasks start and end just after a falling edge
  task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [7:0] d);
    addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic set_mask(input logic [1:0] en);
    logic [7:0] dummy;
    if (en[0]) bus_wr(EN0, 8'hA5); else bus_rd(EN0, dummy);
    if (en[1]) bus_wr(EN1, 8'h3C); else bus_rd(EN1, dummy);
  endtask

  // read back enable state through irq_o with one request raised at a time
  task automatic probe_en(input string req, input logic [1:0] exp);
    logic [1:0] save;
    save = drv_irq_i;
    drv_irq_i = 2'b01; #1 check(req, irq_o, exp[0]);
    drv_irq_i = 2'b10; #1 check(req, irq_o, exp[1]);
    drv_irq_i = save; #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [11:0] odd_addr [6];
    logic [7:0]  wvals [4];
    odd_addr = '{12'h000, 12'h881, 12'h884, 12'hC81, 12'h480, 12'hFFF};
    wvals = '{8'h00, 8'h01, 8'h80, 8'hFF};

    drv_irq_i = 2'b11;
    repeat (2) @(negedge clk_i);
    check("R1 irq during reset", irq_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 irq after reset", irq_o, 0);
    probe_en("R1 enables after reset", 2'b00);

    // R5 R4: every mask state against every request pattern
    for (int m = 0; m < 4; m++) begin
      set_mask(2'(m));
      for (int r = 0; r < 4; r++) begin
        drv_irq_i = 2'(r);
        #1 check("R5 combined irq", irq_o, ((m & r) != 0) ? 1 : 0);
        bus_rd(ST0, d);
        check("R4 status ch0", d, r & 1);
        bus_rd(ST1, d);
        check("R4 status ch1", d, (r >> 1) & 1);
      end
    end

    // R2: data value plays no part
    drv_irq_i = 2'b00;
    for (int i = 0; i < 4; i++) begin
      set_mask(2'b00);
      bus_wr(EN0, wvals[i]);
      probe_en("R2 write sets ch0", 2'b01);
      bus_wr(EN1, wvals[i]);
      probe_en("R2 write sets ch1", 2'b11);
    end

    // R3: read clears, returns zero; R6 other channel untouched
    bus_rd(EN0, d);
    check("R3 ctrl read data", d, 0);
    probe_en("R3 R6 read clears ch0 only", 2'b10);
    bus_rd(EN1, d);
    check("R3 ctrl read data", d, 0);
    probe_en("R3 read clears ch1", 2'b00);
    set_mask(2'b10);
    bus_wr(EN0, 8'h00);
    probe_en("R6 ch0 write keeps ch1", 2'b11);

    // steering: one channel routed, other masked
    set_mask(2'b00);
    bus_wr(EN1, 8'h00); bus_rd(EN0, d);
    drv_irq_i = 2'b01; #1 check("R5 routed ch1 ignores ch0", irq_o, 0);
    drv_irq_i = 2'b10; #1 check("R5 routed ch1 fires", irq_o, 1);

    // R7: status and unmapped writes leave masks alone
    set_mask(2'b00);
    bus_wr(ST0, 8'hFF); bus_wr(ST1, 8'hFF);
    for (int i = 0; i < 6; i++) bus_wr(odd_addr[i], 8'hFF);
    probe_en("R7 stray writes", 2'b00);
    set_mask(2'b11);
    drv_irq_i = 2'b11;
    for (int i = 0; i < 6; i++) begin
      bus_rd(odd_addr[i], d);
      check("R7 unmapped read data", d, 0);
    end
    bus_rd(ST0, d); bus_rd(ST1, d);
    probe_en("R7 stray reads", 2'b11);

    // R8: both strobes on one control location
    set_mask(2'b00);
    addr_i = EN0; rd_i = 1'b1; wr_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0; wr_i = 1'b0;
    probe_en("R8 write priority", 2'b01);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule